// File: doc/BRIEF.md
# Privileged Register Access Checker

This block stands between a host bus and a peripheral's register file. It is the only path into that file. Every offset in the peripheral's map belongs to one of two segments. The fixed segment holds the global control words, and only a supervisor may touch it. The assignable segment holds the command table, the result table and the rest of the registers. A run-time mode bit decides whether that segment is also open to user-mode accesses.

Each bus request carries an offset, a read/write flag, write data and a flag that says the master is in supervisor mode. The checker decides whether the request is allowed. An allowed request to an ordinary register is forwarded to the peripheral with a one-cycle strobe. The mode bit itself is stored inside the checker. It is read and written at a fixed offset in the fixed segment. Each request ends with exactly one response pulse: a normal acknowledge or a transfer-error acknowledge. A refused request has no side effect and reads back zero.

The request side is a valid/ready channel. A request is taken in any cycle where `req_valid` and `req_ready` are both high. The response follows in the next cycle. While that response is pending, `req_ready` is low. The master must hold its request stable until it is taken, so the peak rate is one access every two cycles. Nothing can stall the response side: `rsp_ack`, `rsp_err` and `rsp_rdata` are valid only in their pulse cycle.

Top module: `prv_access_gate`

## Requirements
- R1: An offset below `SUP_WORDS` lies in the fixed segment, and every other offset lies in the assignable segment. With the defaults, 0x0F is the last fixed word and 0x10 is the first assignable word.
- R2: A request to the fixed segment with `req_super` low gets `rsp_err` and no `rsp_ack`, whatever the mode bit holds.
- R3: A request to the assignable segment with `req_super` low gets `rsp_err` when the mode bit is 0 and `rsp_ack` when it is 1.
- R4: A request with `req_super` high gets `rsp_ack` at every offset.
- R5: A refused write changes nothing. `per_stb` stays low and the mode bit keeps its value.
- R6: A refused read, like every error response, returns `rsp_rdata` equal to zero.
- R7: Each taken request produces exactly one one-cycle pulse on either `rsp_ack` or `rsp_err`, in the cycle after it is taken. No pulse appears without a request.
- R8: The mode bit sits at offset `MODE_ADDR` (default 0), data bit `MODE_BIT` (default 0); 1 means the assignable segment is unrestricted. It resets to 0. A read returns the bit in that position with all other bits zero. A write that changes it applies from the very next request.
- R9: `req_ready` is low while `rst` is high and in the cycle after a request is taken. It is high otherwise.
- R10: An allowed request to any offset other than `MODE_ADDR` raises `per_stb` for the cycle in which it is taken. `per_addr`, `per_write` and `per_wdata` carry the request in that cycle. A read returns the `per_rdata` seen in that cycle on `rsp_rdata`. An allowed write returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Checker can take a request |
| req_addr | input | ADDR_W | Word offset in the peripheral map |
| req_write | input | 1 | 1 = write, 0 = read |
| req_super | input | 1 | Master is in supervisor mode |
| req_wdata | input | DATA_W | Write data |
| rsp_ack | output | 1 | Normal acknowledge pulse |
| rsp_err | output | 1 | Transfer-error acknowledge pulse |
| rsp_rdata | output | DATA_W | Read data, valid with the pulse |
| per_stb | output | 1 | Forwarded access strobe to the peripheral |
| per_write | output | 1 | Forwarded direction |
| per_addr | output | ADDR_W | Forwarded offset |
| per_wdata | output | DATA_W | Forwarded write data |
| per_rdata | input | DATA_W | Peripheral read data for `per_addr` |

## Verification
The bench uses the default parameters: `ADDR_W` = 8, `DATA_W` = 16, `SUP_WORDS` = 16, `MODE_ADDR` = 0 and `MODE_BIT` = 0. With a 256-word map and a 16-word fixed segment, the bench can reach both words on either side of the segment edge, the top word 0xFF and the mode word itself. It can also follow a mode change with an access on the very next request. The peripheral model returns a data word built from the offset, so a forwarded read is easy to tell apart from a zero or a mode-bit read.

// File: rtl/prv_pkg.sv
package prv_pkg;

  // Which part of the address map an offset falls in.
  typedef enum logic {
    SEG_FIXED  = 1'b0,
    SEG_ASSIGN = 1'b1
  } seg_e;

  // Result of the privilege check for one request.
  typedef enum logic {
    VERD_DENY  = 1'b0,
    VERD_ALLOW = 1'b1
  } verdict_e;

endpackage

// File: rtl/prv_decode.sv
module prv_decode #(
  parameter int ADDR_W    = 8,
  parameter int SUP_WORDS = 16,
  parameter int MODE_ADDR = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output prv_pkg::seg_e     seg,
  output logic              is_mode
);
  localparam logic [ADDR_W:0]   LIMIT    = (ADDR_W+1)'(SUP_WORDS);
  localparam logic [ADDR_W-1:0] MODE_OFS = ADDR_W'(MODE_ADDR);

  always_comb begin
    seg     = ({1'b0, addr} < LIMIT) ? prv_pkg::SEG_FIXED : prv_pkg::SEG_ASSIGN;
    is_mode = (addr == MODE_OFS);
  end
endmodule

// File: rtl/prv_policy.sv
module prv_policy (
  input  prv_pkg::seg_e     seg,
  input  logic              super_mode,
  input  logic              assign_open,
  output prv_pkg::verdict_e verdict
);
  always_comb begin
    if (super_mode)
      verdict = prv_pkg::VERD_ALLOW;
    else if (seg == prv_pkg::SEG_ASSIGN && assign_open)
      verdict = prv_pkg::VERD_ALLOW;
    else
      verdict = prv_pkg::VERD_DENY;
  end
endmodule

// File: rtl/prv_cfg.sv
module prv_cfg #(
  parameter int DATA_W   = 16,
  parameter int MODE_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_bit,
  output logic              mode_open,
  output logic [DATA_W-1:0] rd_word
);
  logic mode_q;

  always_ff @(posedge clk) begin
    if (rst)        mode_q <= 1'b0;
    else if (wr_en) mode_q <= wr_bit;
  end

  assign mode_open = mode_q;

  // Place the mode bit at its data position; all other bits read zero.
  for (genvar i = 0; i < DATA_W; i++) begin : g_rd
    if (i == MODE_BIT) begin : g_bit
      assign rd_word[i] = mode_q;
    end else begin : g_zero
      assign rd_word[i] = 1'b0;
    end
  end
endmodule

// File: rtl/prv_resp.sv
module prv_resp #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              allow,
  input  logic [DATA_W-1:0] rdata_next,
  output logic              busy,
  output logic              ack,
  output logic              err,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      ack   <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      busy  <= fire;
      ack   <= fire & allow;
      err   <= fire & ~allow;
      rdata <= fire ? rdata_next : '0;
    end
  end
endmodule

// File: rtl/prv_access_gate.sv
module prv_access_gate #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int SUP_WORDS = 16,
  parameter int MODE_ADDR = 0,
  parameter int MODE_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_super,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_ack,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              per_stb,
  output logic              per_write,
  output logic [ADDR_W-1:0] per_addr,
  output logic [DATA_W-1:0] per_wdata,
  input  logic [DATA_W-1:0] per_rdata
);
  prv_pkg::seg_e     seg;
  prv_pkg::verdict_e verdict;
  logic              is_mode;
  logic              mode_open;
  logic [DATA_W-1:0] mode_word;
  logic              busy;
  logic              take;
  logic              allow;
  logic [DATA_W-1:0] rdata_next;

  prv_decode #(
    .ADDR_W   (ADDR_W),
    .SUP_WORDS(SUP_WORDS),
    .MODE_ADDR(MODE_ADDR)
  ) u_dec (
    .addr   (req_addr),
    .seg    (seg),
    .is_mode(is_mode)
  );

  prv_policy u_pol (
    .seg        (seg),
    .super_mode (req_super),
    .assign_open(mode_open),
    .verdict    (verdict)
  );

  assign req_ready = ~busy & ~rst;
  assign take      = req_valid & req_ready;
  assign allow     = (verdict == prv_pkg::VERD_ALLOW);

  prv_cfg #(
    .DATA_W  (DATA_W),
    .MODE_BIT(MODE_BIT)
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (take & allow & is_mode & req_write),
    .wr_bit   (req_wdata[MODE_BIT]),
    .mode_open(mode_open),
    .rd_word  (mode_word)
  );

  // Forward allowed requests for ordinary registers to the peripheral.
  assign per_stb   = take & allow & ~is_mode;
  assign per_write = req_write;
  assign per_addr  = req_addr;
  assign per_wdata = req_wdata;

  always_comb begin
    if (!allow || req_write) rdata_next = '0;
    else if (is_mode)        rdata_next = mode_word;
    else                     rdata_next = per_rdata;
  end

  prv_resp #(
    .DATA_W(DATA_W)
  ) u_rsp (
    .clk       (clk),
    .rst       (rst),
    .fire      (take),
    .allow     (allow),
    .rdata_next(rdata_next),
    .busy      (busy),
    .ack       (rsp_ack),
    .err       (rsp_err),
    .rdata     (rsp_rdata)
  );
endmodule

module prv_access_gate_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int SUP_WORDS = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_super,
  input logic              rsp_ack,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              per_stb,
  input logic              mode_open
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(SUP_WORDS);

  logic take;
  logic in_fixed;
  assign take     = req_valid & req_ready;
  assign in_fixed = ({1'b0, req_addr} < LIMIT);

  p_single_resp_r7: assert property (@(posedge clk) disable iff (rst)
    !(rsp_ack && rsp_err));
  p_resp_follows_r7: assert property (@(posedge clk) disable iff (rst)
    take |=> (rsp_ack || rsp_err));
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_ack || rsp_err) |-> $past(take));
  p_user_fixed_r2: assert property (@(posedge clk) disable iff (rst)
    (take && !req_super && in_fixed) |=> rsp_err);
  p_user_assign_r3: assert property (@(posedge clk) disable iff (rst)
    (take && !req_super && !in_fixed) |=> (rsp_ack == $past(mode_open)));
  p_super_ok_r4: assert property (@(posedge clk) disable iff (rst)
    (take && req_super) |=> rsp_ack);
  p_err_zero_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_rdata == '0));
  p_no_user_stb_fixed_r5: assert property (@(posedge clk) disable iff (rst)
    (per_stb && !req_super) |-> !in_fixed);
  p_ready_drop_r9: assert property (@(posedge clk) disable iff (rst)
    take |=> !req_ready);
endmodule

bind prv_access_gate prv_access_gate_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .SUP_WORDS(SUP_WORDS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_addr (req_addr),
  .req_super(req_super),
  .rsp_ack  (rsp_ack),
  .rsp_err  (rsp_err),
  .rsp_rdata(rsp_rdata),
  .per_stb  (per_stb),
  .mode_open(mode_open)
);

// File: tb/sim_prv_access_gate.sv
module sim_prv_access_gate;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_write = 1'b0;
  logic          req_super = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_ack, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic          per_stb, per_write;
  logic [AW-1:0] per_addr;
  logic [DW-1:0] per_wdata;
  logic [DW-1:0] per_rdata;

  always #5 clk = ~clk;

  // Peripheral model: read data is a marker byte followed by the offset.
  assign per_rdata = {8'hC3, per_addr};

  prv_access_gate u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_super(req_super),
    .req_wdata(req_wdata), .rsp_ack(rsp_ack), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .per_stb(per_stb), .per_write(per_write),
    .per_addr(per_addr), .per_wdata(per_wdata), .per_rdata(per_rdata)
  );

  typedef struct {
    logic          ack;
    logic          err;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  exp_t   sb[$];
  int     n_chk  = 0;
  int     n_bad  = 0;
  logic   model_open = 1'b0;
  bit     done = 1'b0;

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  // Driver: issue one request, predict its response and push it to the scoreboard.
  task automatic access(input logic [AW-1:0] a, input logic wr, input logic sup,
                        input logic [DW-1:0] wd, input string tag);
    exp_t e;
    logic ok;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_addr = a; req_write = wr; req_super = sup; req_wdata = wd; req_valid = 1'b1;
    ok = sup || (a >= 8'd16 && model_open);
    e.ack = ok;
    e.err = !ok;
    if (!ok || wr)   e.data = '0;
    else if (a == 0) e.data = {15'b0, model_open};
    else             e.data = {8'hC3, a};
    e.tag = tag;
    sb.push_back(e);
    #1;
    check(per_stb == (ok && a != 0), {tag, " R10/R5 per_stb"},
          $sformatf("%0b", per_stb), $sformatf("%0b", ok && a != 0));
    if (ok && wr && a == 0) model_open = wd[0];
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    check(req_ready == 1'b0, {tag, " R9 ready low after take"},
          $sformatf("%0b", req_ready), "0");
  endtask

  // Monitor: compare each response pulse against the oldest prediction.
  always @(negedge clk) begin
    if (!rst && !done && (rsp_ack || rsp_err)) begin
      if (sb.size() == 0) begin
        check(1'b0, "R7 unexpected response", $sformatf("ack=%0b err=%0b", rsp_ack, rsp_err), "none");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rsp_ack == e.ack && rsp_err == e.err && rsp_rdata == e.data, e.tag,
              $sformatf("ack=%0b err=%0b data=%h", rsp_ack, rsp_err, rsp_rdata),
              $sformatf("ack=%0b err=%0b data=%h", e.ack, e.err, e.data));
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 0 && rsp_ack == 0 && rsp_err == 0, "R9 reset state",
          $sformatf("rdy=%0b ack=%0b err=%0b", req_ready, rsp_ack, rsp_err), "0 0 0");
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R9 ready after reset", $sformatf("%0b", req_ready), "1");

    access(8'h00, 0, 1, 16'h0000, "R8 mode resets to 0");
    access(8'h20, 0, 0, 16'h0000, "R3 user read assignable, restricted");
    access(8'h05, 1, 0, 16'h1234, "R2 user write fixed");
    access(8'h00, 1, 0, 16'h0001, "R5 user write to mode refused");
    access(8'h00, 0, 1, 16'h0000, "R5 mode unchanged after refused write");
    access(8'h30, 1, 1, 16'hBEEF, "R4 supervisor write assignable");
    access(8'h30, 0, 1, 16'h0000, "R10 supervisor read forwarded");
    access(8'h07, 0, 1, 16'h0000, "R4 supervisor read fixed");
    access(8'h00, 1, 1, 16'hFFFF, "R8 supervisor sets mode");
    access(8'h40, 0, 0, 16'h0000, "R8 R3 user read on next request");
    access(8'h41, 1, 0, 16'h5555, "R3 user write assignable, open");
    access(8'h00, 0, 1, 16'h0000, "R8 mode reads 1 at bit 0");
    access(8'h0F, 0, 0, 16'h0000, "R1 last fixed word refused");
    access(8'h10, 0, 0, 16'h0000, "R1 first assignable word allowed");
    access(8'h00, 0, 0, 16'h0000, "R2 R6 user read mode refused, zero data");
    access(8'h00, 1, 1, 16'hFFFE, "R8 supervisor clears mode");
    access(8'h10, 0, 0, 16'h0000, "R8 R6 user refused on next request");
    access(8'hFF, 1, 0, 16'h0001, "R3 user write top word refused");
    access(8'hFF, 0, 1, 16'h0000, "R4 R10 supervisor read top word");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R7 every request answered",
          $sformatf("%0d pending", sb.size()), "0 pending");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule